// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Controller

This block collects the request flags of six interrupt sources in a small 8-bit microcontroller and decides which one the core should service next. Software sets it up through three byte-wide registers on a special-function-register bus: a source-enable register with a global enable, and two priority registers. One gives the low bit and one the high bit of each source's two-bit priority level. The block offers the winning request to the core as a valid/ready stream whose payload is the vector address.

The controller keeps a record of which priority levels are being serviced. This record moves forward when the core accepts a vector and moves back when the core signals a return from interrupt. As a result, a higher-level request can preempt a running handler, and an equal or lower-level request has to wait. The two external request lines are latched inside the block, either by level or by rising edge. For the two timer-overflow flags and for an edge-latched external flag, the block issues a hardware clear when that source is accepted.

Back-pressure works as follows. `irq_valid` rises whenever an eligible request exists, and `irq_vector` names the current winner. A vector is consumed only in a cycle where both `irq_valid` and `irq_ready` are high. While the core holds `irq_ready` low, nothing is consumed. During that time the offer is re-evaluated every cycle, so a newly arrived higher-priority request replaces the pending one. Raising `irq_ready` while `irq_valid` is low has no effect.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00, `irq_valid` is low, both clear strobes are low and no priority level is in service.
- R2: The enable register is at 0xA8, the priority-low register at 0xB8 and the priority-high register at 0xB7. A write takes effect on the next clock edge and `sfr_rdata` returns the selected register combinationally. Enable bit 6 and priority bits 7:6 read as 0 and ignore writes. Writes to any other address change nothing.
- R3: Enable bit 7 is the global enable. When it is 0, `irq_valid` stays low whatever the sources and source enables are.
- R4: Each source has one bit in the enable register: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2. A source whose bit is 0 is never offered. Both priority registers use the same bit mapping.
- R5: A source's level is {high bit, low bit}, where 3 is the highest and 0 the lowest. An eligible request at a higher level wins over any request at a lower level.
- R6: Among eligible requests at the same level, the winner follows the fixed order external 0, timer 0, external 1, timer 1, serial, timer 2. The first in this order wins.
- R7: The vector for the source at position n of that order (0 to 5) is 8·n + 3, which gives 0x03, 0x0B, 0x13, 0x1B, 0x23 and 0x2B.
- R8: A request is offered only when its level is strictly above every level currently in service.
- R9: Acceptance (valid and ready) marks the winner's level as in service from the next edge. A one-cycle `reti` pulse removes the highest level in service.
- R10: When timer 0 or timer 1 is accepted, `tf0_clr` or `tf1_clr` is high for that cycle. Serial (`ri` or `ti`) and timer 2 (`tf2` or `exf2`) requests are never cleared by the block.
- R11: An external line in edge mode (`extN_edge`=1) latches a rising edge, and the latch is cleared when that source is accepted. In level mode the request follows the line with one cycle of delay and is not cleared. Either way, a pin change reaches `irq_valid` one cycle later.
- R12: Stream rules: a vector is consumed only when `irq_valid` and `irq_ready` are both high. Raising `irq_ready` while `irq_valid` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data of the addressed register |
| ext0_pin | input | 1 | External request line 0, active high |
| ext0_edge | input | 1 | 1: line 0 latches rising edges; 0: level mode |
| ext1_pin | input | 1 | External request line 1, active high |
| ext1_edge | input | 1 | Trigger mode of line 1 |
| tf0 | input | 1 | Timer 0 overflow flag |
| tf1 | input | 1 | Timer 1 overflow flag |
| ri | input | 1 | Serial receive flag |
| ti | input | 1 | Serial transmit flag |
| tf2 | input | 1 | Timer 2 overflow flag |
| exf2 | input | 1 | Timer 2 external flag |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | Core accepts the offered vector |
| irq_vector | output | 8 | Vector address of the offer |
| reti | input | 1 | Return-from-interrupt pulse |
| tf0_clr | output | 1 | Clear strobe for timer 0 flag |
| tf1_clr | output | 1 | Clear strobe for timer 1 flag |

## Verification
Timer and serial flags are combinational inputs to the arbitration, so `irq_valid` and `irq_vector` respond in the same cycle they are driven. External lines and register writes pass through one register and appear one edge later. The in-service state changes at the edge that closes a handshake or a `reti` cycle, and the clear strobes are checked during the handshake cycle itself. The bench drives inputs just after a rising edge, samples on the falling edge, and pushes each expected vector into a queue at the moment it raises `irq_ready`. A falling-edge monitor pops the queue for every handshake, which catches both a wrong vector and any unexpected acceptance.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Source count and priority depth are fixed by the source wiring.
  localparam int NSRC  = 6;
  localparam int NLVL  = 4;
  localparam int LVL_W = $clog2(NLVL);
  localparam int IDX_W = $clog2(NSRC);

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IDX_W-1:0] idx_t;

  // Position in the polling order; also the bit position in the registers.
  typedef enum logic [IDX_W-1:0] {
    SRC_X0 = 3'd0,
    SRC_T0 = 3'd1,
    SRC_X1 = 3'd2,
    SRC_T1 = 3'd3,
    SRC_SP = 3'd4,
    SRC_T2 = 3'd5
  } src_e;

  function automatic int vec_num(input int idx, input int base, input int step);
    return base + step * idx;
  endfunction

endpackage

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs
  import irq_vec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_EN  = 8'hA8,
  parameter logic [ADDR_W-1:0] ADDR_PLO = 8'hB8,
  parameter logic [ADDR_W-1:0] ADDR_PHI = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ea_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   plo_o,
  output logic [NSRC-1:0]   phi_o
);

  localparam int EA_BIT = DATA_W - 1;

  logic            ea_q;
  logic [NSRC-1:0] en_q, plo_q, phi_q;
  logic            hit_en, hit_plo, hit_phi;
  logic            unused_wbits;

  assign hit_en  = (addr_i == ADDR_EN);
  assign hit_plo = (addr_i == ADDR_PLO);
  assign hit_phi = (addr_i == ADDR_PHI);

  // Bits between the source field and the global enable are reserved.
  assign unused_wbits = ^wdata_i[EA_BIT-1:NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= 1'b0;
      en_q  <= '0;
      plo_q <= '0;
      phi_q <= '0;
    end else if (wr_i) begin
      if (hit_en) begin
        ea_q <= wdata_i[EA_BIT];
        en_q <= wdata_i[NSRC-1:0];
      end
      if (hit_plo) plo_q <= wdata_i[NSRC-1:0];
      if (hit_phi) phi_q <= wdata_i[NSRC-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_en) begin
      rdata_o[NSRC-1:0] = en_q;
      rdata_o[EA_BIT]   = ea_q;
    end else if (hit_plo) begin
      rdata_o[NSRC-1:0] = plo_q;
    end else if (hit_phi) begin
      rdata_o[NSRC-1:0] = phi_q;
    end
  end

  assign ea_o  = ea_q;
  assign en_o  = en_q;
  assign plo_o = plo_q;
  assign phi_o = phi_q;

  assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit_en) |=> (en_q == $past(wdata_i[NSRC-1:0])) && (ea_q == $past(wdata_i[EA_BIT])));

  assert_other_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !hit_en && !hit_plo && !hit_phi) |=> $stable(en_q) && $stable(plo_q) && $stable(phi_q));

endmodule

// File: rtl/irq_ext_flag.sv
module irq_ext_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic flag_o
);

  logic pin_q, flag_q, rise;

  assign rise = pin_i & ~pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (edge_i) flag_q <= rise | (flag_q & ~clr_i);
      else        flag_q <= pin_i;
    end
  end

  assign flag_o = flag_q;

  assert_edge_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && clr_i && !rise) |=> !flag_q);

  assert_edge_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && rise) |=> flag_q);

  assert_level_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_i |=> (flag_q == $past(pin_i)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic            ea_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] plo_i,
  input  logic [NSRC-1:0] phi_i,
  input  logic [NLVL-1:0] isr_i,
  output logic            valid_o,
  output idx_t            idx_o,
  output lvl_t            lvl_o
);

  lvl_t            src_lvl [NSRC];
  logic [NSRC-1:0] elig;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_lvl[s] = {phi_i[s], plo_i[s]};
    assign elig[s]    = pend_i[s] & en_i[s] & ea_i;
  end

  logic busy;
  lvl_t ceil_lvl;

  always_comb begin
    busy     = |isr_i;
    ceil_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_i[l]) ceil_lvl = lvl_t'(l);
    end
  end

  // Ascending level scan: the last group found is the highest.
  // Descending source scan: the last hit is first in polling order.
  always_comb begin
    logic found;
    idx_t fidx;
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int l = 0; l < NLVL; l++) begin
      found = 1'b0;
      fidx  = '0;
      for (int s = NSRC - 1; s >= 0; s--) begin
        if (elig[s] && (src_lvl[s] == lvl_t'(l))) begin
          found = 1'b1;
          fidx  = idx_t'(s);
        end
      end
      if (found && (!busy || (lvl_t'(l) > ceil_lvl))) begin
        valid_o = 1'b1;
        idx_o   = fidx;
        lvl_o   = lvl_t'(l);
      end
    end
  end

endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_vec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  lvl_t            take_lvl_i,
  input  logic            reti_i,
  output logic [NLVL-1:0] mask_o
);

  logic [NLVL-1:0] mask_q, top_bit, set_bit;

  always_comb begin
    top_bit = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (mask_q[l]) top_bit = NLVL'(1) << l;
    end
    set_bit = take_i ? (NLVL'(1) << take_lvl_i) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q & ~(reti_i ? top_bit : '0)) | set_bit;
  end

  assign mask_o = mask_q;

  assert_take_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> mask_q[$past(take_lvl_i)]);

  assert_reti_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_i && (mask_q != '0)) |=>
      ($countones(mask_q) == $countones($past(mask_q)) - 1));

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter logic [ADDR_W-1:0] ADDR_EN  = 8'hA8,
  parameter logic [ADDR_W-1:0] ADDR_PLO = 8'hB8,
  parameter logic [ADDR_W-1:0] ADDR_PHI = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              ext0_pin,
  input  logic              ext0_edge,
  input  logic              ext1_pin,
  input  logic              ext1_edge,
  input  logic              tf0,
  input  logic              tf1,
  input  logic              ri,
  input  logic              ti,
  input  logic              tf2,
  input  logic              exf2,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              reti,
  output logic              tf0_clr,
  output logic              tf1_clr
);

  localparam int NEXT = 2;

  logic            ea;
  logic [NSRC-1:0] en, plo, phi, pend;
  logic [NLVL-1:0] isr_mask;
  logic [NEXT-1:0] ext_pin, ext_edge, ext_flag;
  logic            take;
  idx_t            win_idx;
  lvl_t            win_lvl;

  irq_sfr_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ADDR_EN(ADDR_EN), .ADDR_PLO(ADDR_PLO), .ADDR_PHI(ADDR_PHI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(sfr_wr), .addr_i(sfr_addr),
    .wdata_i(sfr_wdata), .rdata_o(sfr_rdata),
    .ea_o(ea), .en_o(en), .plo_o(plo), .phi_o(phi)
  );

  assign ext_pin  = {ext1_pin, ext0_pin};
  assign ext_edge = {ext1_edge, ext0_edge};

  // External line e sits at polling position 2*e.
  for (genvar e = 0; e < NEXT; e++) begin : g_ext
    logic clr;
    assign clr = take && (win_idx == idx_t'(2 * e));
    irq_ext_flag u_flag (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin[e]), .edge_i(ext_edge[e]),
      .clr_i(clr), .flag_o(ext_flag[e])
    );
  end

  assign pend = {tf2 | exf2, ri | ti, tf1, ext_flag[1], tf0, ext_flag[0]};

  irq_arbiter u_arb (
    .pend_i(pend), .ea_i(ea), .en_i(en), .plo_i(plo), .phi_i(phi),
    .isr_i(isr_mask), .valid_o(irq_valid), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign take = irq_valid & irq_ready;

  irq_inservice u_isr (
    .clk(clk), .rst_n(rst_n), .take_i(take), .take_lvl_i(win_lvl),
    .reti_i(reti), .mask_o(isr_mask)
  );

  assign irq_vector = VEC_W'(vec_num(int'(win_idx), VEC_BASE, VEC_STEP));
  assign tf0_clr    = take && (win_idx == SRC_T0);
  assign tf1_clr    = take && (win_idx == SRC_T1);

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ea);

  assert_strict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((isr_mask >> win_lvl) == '0));

  assert_clr_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tf0_clr, tf1_clr}));

  assert_clr_needs_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tf0_clr || tf1_clr) |-> (irq_valid && irq_ready));

  assert_idle_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && !reti) |=> $stable(isr_mask));

endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
  logic       ext0_pin = 0, ext0_edge = 0, ext1_pin = 0, ext1_edge = 0;
  logic       tf0 = 0, tf1 = 0, ri = 0, ti = 0, tf2 = 0, exf2 = 0;
  logic       irq_valid, irq_ready = 0, reti = 0, tf0_clr, tf1_clr;
  logic [7:0] irq_vector;

  localparam logic [7:0] A_EN = 8'hA8, A_LO = 8'hB8, A_HI = 8'hB7;

  always #10 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext0_pin(ext0_pin), .ext0_edge(ext0_edge), .ext1_pin(ext1_pin), .ext1_edge(ext1_edge),
    .tf0(tf0), .tf1(tf1), .ri(ri), .ti(ti), .tf2(tf2), .exf2(exf2),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
    .reti(reti), .tf0_clr(tf0_clr), .tf1_clr(tf1_clr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int vec; string tag; } exp_t;
  exp_t sb[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every handshake pops one expected vector.
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected handshake actual=%0h expected=none", irq_vector);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (int'(irq_vector) != e.vec) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", e.tag, irq_vector, e.vec);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    cyc();
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    cyc();
    sfr_wr = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, int exp, string tag);
    cyc();
    sfr_addr = a;
    @(negedge clk);
    chk(tag, int'(sfr_rdata), exp);
  endtask

  task automatic vchk(bit v, int vec, string tag);
    @(negedge clk);
    chk(tag, int'(irq_valid), int'(v));
    if (v) chk(tag, int'(irq_vector), vec);
  endtask

  task automatic reti_pulse();
    cyc(); reti = 1;
    cyc(); reti = 0;
  endtask

  // Driver: queues the expected vector, then accepts the offer.
  task automatic take(int vec, bit c0, bit c1, string tag);
    cyc();
    sb.push_back('{vec, tag});
    irq_ready = 1;
    @(negedge clk);
    chk({tag, " tf0_clr R10"}, int'(tf0_clr), int'(c0));
    chk({tag, " tf1_clr R10"}, int'(tf1_clr), int'(c1));
    cyc();
    irq_ready = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    rd_chk(A_EN, 'h00, "R1 enable");
    rd_chk(A_LO, 'h00, "R1 prio low");
    rd_chk(A_HI, 'h00, "R1 prio high");
    vchk(0, 0, "R1 idle");
    chk("R1 clr", int'({tf0_clr, tf1_clr}), 0);

    // R2: register access and reserved bits
    wr(A_EN, 8'hFF); rd_chk(A_EN, 'hBF, "R2 enable reserved");
    wr(A_LO, 8'hFF); rd_chk(A_LO, 'h3F, "R2 prio low reserved");
    wr(A_HI, 8'hC5); rd_chk(A_HI, 'h05, "R2 prio high reserved");
    wr(A_EN, 8'h00); wr(A_LO, 8'h00); wr(A_HI, 8'h00);
    wr(8'h10, 8'hFF); rd_chk(A_EN, 'h00, "R2 unmapped write");

    // R3: global enable
    wr(A_EN, 8'h3F);
    cyc(); tf0 = 1; ti = 1; tf1 = 1;
    vchk(0, 0, "R3 global off");
    wr(A_EN, 8'hBF);
    vchk(1, 'h0B, "R6 poll t0 first");

    // R6/R7/R8/R10: same-level ordering and clears
    take('h0B, 1, 0, "R7 vector t0");
    tf0 = 0;
    vchk(0, 0, "R8 same level waits");
    reti_pulse();
    vchk(1, 'h1B, "R6 poll t1 next");
    take('h1B, 0, 1, "R10 t1 clear");
    tf1 = 0;
    reti_pulse();
    vchk(1, 'h23, "R6 poll serial");
    take('h23, 0, 0, "R10 serial no clear");
    vchk(0, 0, "R8 serial in service");
    reti_pulse();
    vchk(1, 'h23, "R10 serial flag kept");
    cyc(); ti = 0;
    vchk(0, 0, "R10 serial dropped");

    // R5/R8/R9/R11: nesting across levels
    wr(A_LO, 8'h21); wr(A_HI, 8'h24);
    cyc(); ext1_edge = 1; ext0_pin = 1;
    vchk(0, 0, "R11 level latency");
    vchk(1, 'h03, "R11 level seen");
    take('h03, 0, 0, "R7 vector x0");
    vchk(0, 0, "R8 level1 busy");
    cyc(); tf0 = 1;
    vchk(0, 0, "R8 lower waits");
    cyc(); tf2 = 1;
    vchk(1, 'h2B, "R5 level3 preempts");
    take('h2B, 0, 0, "R8 nested t2");
    tf2 = 0; ext1_pin = 1;
    cyc(); ext1_pin = 0;
    vchk(0, 0, "R8 level2 under level3");
    reti_pulse();
    vchk(1, 'h13, "R9 reti reopens level2");
    take('h13, 0, 0, "R7 vector x1");
    reti_pulse();
    vchk(0, 0, "R11 edge flag cleared");
    reti_pulse();
    vchk(1, 'h03, "R5 level1 over level0");
    cyc(); ext0_pin = 0;
    vchk(1, 'h03, "R11 pin drop latency");
    vchk(1, 'h0B, "R11 level follows pin");

    // R4/R12: source enable and idle ready
    wr(A_EN, 8'hBD);
    vchk(0, 0, "R4 source disabled");
    cyc(); irq_ready = 1;
    cyc(); irq_ready = 0;
    wr(A_EN, 8'hBF);
    vchk(1, 'h0B, "R12 idle ready ignored");
    take('h0B, 1, 0, "R4 t0 enabled");
    tf0 = 0;
    reti_pulse();
    vchk(0, 0, "R9 all levels free");

    // R11: edge mode with line held high
    cyc(); ext1_pin = 1;
    vchk(0, 0, "R11 edge latency");
    vchk(1, 'h13, "R11 edge seen");
    take('h13, 0, 0, "R11 edge take");
    reti_pulse();
    vchk(0, 0, "R11 held line no retrigger");
    cyc(); ext1_pin = 0;

    @(negedge clk);
    chk("R12 scoreboard drained", sb.size(), 0);
    finish_run();
  end

endmodule